// File: doc/BRIEF.md
# Frame-Relative Operand Address Generator

This block converts a one-byte register operand, together with a two-bit storage size code, into a signed offset from the current frame. It then adds that offset to a 32-bit frame pointer to produce the byte address where the register is stored. An operand that encodes a negative offset is read as a plain two's complement byte, with the same meaning for every size. An operand that encodes a non-negative offset counts in units of the storage size. As a result, offsets above zero are coarser for wider registers, while offsets below zero stay at single-byte resolution.

An instruction decoder places the operand byte, the size code and the live frame pointer on the inputs and pulses the valid strobe. By default the result is registered, so it appears one clock later and is then held until the next strobe. A parameter selects a purely combinational variant instead.

Top module: `fra_addr_gen`

## Requirements
- R1: An operand in the range 0xC0..0xFF is a negative offset equal to the byte read as two's complement (-64..-1), for every size code; 0xF9 gives -7.
- R2: An operand in the range 0x00..0xBF is a non-negative offset equal to the byte times the size: size code 2'b00 multiplies by 1, 2'b01 by 2 and 2'b10 by 4; 0x03 with code 2'b10 gives 12.
- R3: The decoded offset stays within -64..191 for code 2'b00, -64..382 for code 2'b01 and -64..764 for code 2'b10. It is presented as an 11-bit signed value on `out_index`.
- R4: `out_addr` equals `frame_ptr` plus the sign-extended offset, modulo 2^32. With frame pointer 0x0010_0009, offset -7 gives 0x0010_0002 and offset 12 gives 0x0010_0015.
- R5: Size code 2'b11 is reserved. It sets `out_bad_size` to 1, forces the offset to 0 and makes `out_addr` equal to `frame_ptr`. Legal codes give `out_bad_size` = 0.
- R6: In the registered variant, `out_valid` in a cycle equals `in_valid` of the previous cycle, and the index, address and flag outputs reflect the inputs sampled at that same edge.
- R7: In the registered variant, a cycle with `in_valid` low leaves `out_index`, `out_addr` and `out_bad_size` unchanged.
- R8: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe qualifying the operand inputs |
| opnd | input | 8 | Register operand byte |
| size_code | input | 2 | Storage size: 00 byte, 01 pair, 10 int, 11 reserved |
| frame_ptr | input | 32 | Current frame pointer |
| out_valid | output | 1 | Result valid |
| out_index | output | 11 | Decoded signed frame offset |
| out_addr | output | 32 | Effective storage address |
| out_bad_size | output | 1 | Reserved size code was presented |

## Verification
Every result of the registered variant is due exactly one rising edge after the inputs that produce it. This applies to the valid flag, the index, the address and the reserved-size flag. The bench drives inputs on the falling edge and compares all four outputs on the following falling edge. The comparison is against a behavioural model that is updated only when the strobe was high. Cycles with the strobe low are checked against the held values, so a change that leaks into those cycles shows up in the very next comparison.

// File: rtl/fra_pkg.sv
package fra_pkg;

    // Storage size codes carried on size_code
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_PAIR = 2'b01,
        SZ_INT  = 2'b10,
        SZ_RSVD = 2'b11
    } fra_size_e;

    // log2 of the byte count for a legal size code
    function automatic logic [1:0] size_shift(input fra_size_e sz);
        logic [1:0] sh;
        case (sz)
            SZ_BYTE: sh = 2'd0;
            SZ_PAIR: sh = 2'd1;
            SZ_INT:  sh = 2'd2;
            default: sh = 2'd0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/fra_index_decode.sv
module fra_index_decode
    import fra_pkg::*;
#(
    parameter int OPND_W = 8,
    parameter int IDX_W  = 11
) (
    input  logic [OPND_W-1:0]        opnd,
    input  logic [1:0]               size_code,
    output logic signed [IDX_W-1:0]  index,
    output logic                     bad_size
);

    localparam int EXT_W = IDX_W - OPND_W;

    fra_size_e          sz;
    logic               is_neg;
    logic [IDX_W-1:0]   neg_val;
    logic [IDX_W-1:0]   pos_val;

    always_comb begin
        sz       = fra_size_e'(size_code);
        // the top two operand bits both set mark the negative window
        is_neg   = &opnd[OPND_W-1 -: 2];
        neg_val  = {{EXT_W{opnd[OPND_W-1]}}, opnd};
        pos_val  = {{EXT_W{1'b0}}, opnd} << size_shift(sz);
        bad_size = (sz == SZ_RSVD);
        if (bad_size) begin
            index = '0;
        end else if (is_neg) begin
            index = neg_val;
        end else begin
            index = pos_val;
        end
    end

endmodule

// File: rtl/fra_addr_add.sv
module fra_addr_add #(
    parameter int FP_W  = 32,
    parameter int IDX_W = 11
) (
    input  logic [FP_W-1:0]          frame_ptr,
    input  logic signed [IDX_W-1:0]  index,
    output logic [FP_W-1:0]          addr
);

    localparam int EXT_W = FP_W - IDX_W;

    logic [FP_W-1:0] offs;

    always_comb begin
        offs = {{EXT_W{index[IDX_W-1]}}, index};
        addr = frame_ptr + offs;
    end

endmodule

// File: rtl/fra_addr_gen.sv
module fra_addr_gen #(
    parameter int  OPND_W     = 8,
    parameter int  IDX_W      = 11,
    parameter int  FP_W       = 32,
    parameter bit  REGISTERED = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [OPND_W-1:0]        opnd,
    input  logic [1:0]               size_code,
    input  logic [FP_W-1:0]          frame_ptr,
    output logic                     out_valid,
    output logic signed [IDX_W-1:0]  out_index,
    output logic [FP_W-1:0]          out_addr,
    output logic                     out_bad_size
);

    localparam int EXT_W = FP_W - IDX_W;

    typedef struct packed {
        logic                    valid;
        logic                    bad;
        logic signed [IDX_W-1:0] idx;
        logic [FP_W-1:0]         addr;
    } res_t;

    logic signed [IDX_W-1:0] idx_c;
    logic                    bad_c;
    logic [FP_W-1:0]         addr_c;

    fra_index_decode #(
        .OPND_W (OPND_W),
        .IDX_W  (IDX_W)
    ) u_dec (
        .opnd      (opnd),
        .size_code (size_code),
        .index     (idx_c),
        .bad_size  (bad_c)
    );

    fra_addr_add #(
        .FP_W  (FP_W),
        .IDX_W (IDX_W)
    ) u_add (
        .frame_ptr (frame_ptr),
        .index     (idx_c),
        .addr      (addr_c)
    );

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_c >= -64) && (idx_c <= 764));

    // R5
    rsvd_zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_c |-> (idx_c == '0) && (addr_c == frame_ptr));

    // R1
    neg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_c && (&opnd[OPND_W-1 -: 2])) |-> (idx_c < 0));

    // R4
    addr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_c - frame_ptr) == {{EXT_W{idx_c[IDX_W-1]}}, idx_c});

    generate
        if (REGISTERED) begin : g_reg
            res_t res_d, res_q;

            always_comb begin
                res_d       = res_q;
                res_d.valid = in_valid;
                if (in_valid) begin
                    res_d.bad  = bad_c;
                    res_d.idx  = idx_c;
                    res_d.addr = addr_c;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end

            assign out_valid    = res_q.valid;
            assign out_bad_size = res_q.bad;
            assign out_index    = res_q.idx;
            assign out_addr     = res_q.addr;

            // R6
            valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            // R6
            idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);

            // R7
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_index) && $stable(out_addr)
                              && $stable(out_bad_size));
        end else begin : g_comb
            assign out_valid    = rst_n & in_valid;
            assign out_bad_size = rst_n & bad_c;
            assign out_index    = rst_n ? idx_c : '0;
            assign out_addr     = rst_n ? addr_c : '0;
        end
    endgenerate

endmodule

// File: tb/fra_addr_gen_test.sv
module fra_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opnd = '0;
    logic [1:0]  size_code = '0;
    logic [31:0] frame_ptr = '0;
    logic        out_valid;
    logic signed [10:0] out_index;
    logic [31:0] out_addr;
    logic        out_bad_size;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural model state
    int          m_valid = 0;
    int          m_idx = 0;
    logic [31:0] m_addr = '0;
    int          m_bad = 0;
    string       m_tag = "R8";
    int          stim_q[$];

    always #2 clk = ~clk;

    fra_addr_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .opnd         (opnd),
        .size_code    (size_code),
        .frame_ptr    (frame_ptr),
        .out_valid    (out_valid),
        .out_index    (out_index),
        .out_addr     (out_addr),
        .out_bad_size (out_bad_size)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic compare_all();
        check({"R6 valid ", m_tag}, longint'(out_valid), longint'(m_valid));
        check({m_tag, " index"}, longint'(int'(out_index)), longint'(m_idx));
        check({"R4 addr ", m_tag}, longint'(out_addr), longint'(m_addr));
        check({"R5 flag ", m_tag}, longint'(out_bad_size), longint'(m_bad));
    endtask

    // drive one cycle at the falling edge, compare at the next falling edge
    task automatic step(input bit v, input int op, input int sz, input logic [31:0] fp);
        int idx;
        in_valid  = v;
        opnd      = 8'(op);
        size_code = 2'(sz);
        frame_ptr = fp;
        m_valid   = v;
        if (v) begin
            if (sz == 3) begin
                idx = 0; m_tag = "R5";
            end else if (op >= 192) begin
                idx = op - 256; m_tag = "R1";
            end else begin
                idx = op * (1 << sz); m_tag = "R2";
            end
            stim_q.push_back(idx);
            m_idx  = stim_q.pop_front();
            m_addr = fp + 32'(idx);
            m_bad  = (sz == 3);
        end else begin
            m_tag = "R7";
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 valid", longint'(out_valid), 0);
        check("R8 index", longint'(int'(out_index)), 0);
        check("R8 addr", longint'(out_addr), 0);
        check("R8 flag", longint'(out_bad_size), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 same negative value for every size
        step(1, 8'hF9, 0, 32'h0010_0009);
        step(1, 8'hF9, 1, 32'h0010_0009);
        step(1, 8'hF9, 2, 32'h0010_0009);
        // R2 / R4 worked example
        step(1, 8'h03, 2, 32'h0010_0009);
        // R3 boundaries
        step(1, 8'hC0, 2, 32'h0000_1000);
        step(1, 8'hBF, 0, 32'h0000_1000);
        step(1, 8'hBF, 1, 32'h0000_1000);
        step(1, 8'hBF, 2, 32'h0000_1000);
        step(1, 8'h00, 1, 32'h1234_5678);
        step(1, 8'hFF, 0, 32'h1234_5678);
        // R4 wrap both ways
        step(1, 8'h01, 2, 32'hFFFF_FFFE);
        step(1, 8'hFF, 1, 32'h0000_0000);
        // R5 reserved code
        step(1, 8'h10, 3, 32'hCAFE_0000);
        step(1, 8'hF0, 3, 32'h0000_0003);
        // R7 hold while idle with changing inputs
        step(1, 8'h20, 1, 32'h0000_0100);
        step(0, 8'hC5, 3, 32'hDEAD_BEEF);
        step(0, 8'h7F, 2, 32'h0BAD_F00D);
        step(1, 8'h7F, 2, 32'h0000_0000);

        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 255),
                 $urandom_range(0, 3), $urandom());
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule